// File: doc/BRIEF.md
# Modem Control and Status Register Pair

This block holds the modem control and modem status registers of a 16550-style serial controller. Software writes a 5-bit control word that drives the RTS, DTR, OUT1 and OUT2 outputs and selects a loopback mode. The four asynchronous modem inputs (CTS, DSR, DCD, RI) are synchronized and shown in the upper nibble of the status register. A sticky delta bit in the lower nibble records each change.

Reading the status register clears the delta bits. A single change output tells the interrupt unit that at least one delta bit is set.

In loopback the control bits replace the external inputs as the status source, in a fixed crossed order. The external RTS and DTR pins are then held deasserted.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset the status read value is 0xB0 (DCD, DSR, CTS high, no delta bits) and the control readback is 0x08. The outputs are rts_o=0, dtr_o=0, out1_o=0, out2_o=1 and msc_chg_o=0.
- R2: A control write stores bits 4:0 of ctl_wdata (bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback). The new value is visible on ctl_q after that clock edge, and ctl_q[7:5] always reads zero.
- R3: With loopback off, rts_o, dtr_o, out1_o and out2_o equal control bits 1, 0, 2 and 3.
- R4: With loopback on, rts_o and dtr_o are 0, while out1_o and out2_o still follow control bits 2 and 3.
- R5: With loopback off, stat_q bit 7 shows DCD, bit 6 RI, bit 5 DSR and bit 4 CTS. An input change held before a clock edge appears on the (SYNC_STAGES+1)-th edge, which is the third edge by default, and not earlier.
- R6: Delta bit 3 (DCD), bit 1 (DSR) and bit 0 (CTS) set whenever the matching status bit changes in either direction.
- R7: Delta bit 2 sets only when status bit 6 (RI) goes from 1 to 0. A 0-to-1 change of RI leaves it unchanged.
- R8: Delta bits stay set until the status is read. A one-cycle stat_rd clears all four at the next edge. If a new change is detected at that same edge, its delta bit is set anyway.
- R9: While loopback is on, status bits 7:4 take OUT2, OUT1, DTR and RTS from the control register, one edge after the control register changes. The external modem inputs have no effect.
- R10: msc_chg_o is high exactly when any of stat_q[3:0] is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_q | output | 8 | Control register readback |
| stat_rd | input | 1 | Status read strobe; clears deltas at the next edge |
| stat_q | output | 8 | Status register value |
| cts_i | input | 1 | Clear-to-send input, asynchronous |
| dsr_i | input | 1 | Data-set-ready input, asynchronous |
| dcd_i | input | 1 | Carrier-detect input, asynchronous |
| ri_i | input | 1 | Ring-indicator input, asynchronous |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Data-terminal-ready output |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| msc_chg_o | output | 1 | Modem status change indication |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. With that value the input-to-status latency is exactly three edges, and the bench samples after two and after three edges to pin it down. The short latency also lets a status read be placed on the very edge where a new change is captured, which exercises the read-versus-set collision. Loopback entry and exit are driven from known input levels, so each crossed bit and each delta it raises can be predicted exactly.

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_q,
  input  logic       stat_rd,
  output logic [7:0] stat_q,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       dcd_i,
  input  logic       ri_i,
  output logic       rts_o,
  output logic       dtr_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       msc_chg_o
);
  localparam int              CTL_W    = 5;
  localparam int              LN_W     = 4;
  localparam logic [LN_W-1:0] LINE_RST = 4'b1011;
  localparam logic [CTL_W-1:0] CTL_RST = 5'b01000;
  localparam int B_DTR = 0, B_RTS = 1, B_OUT1 = 2, B_OUT2 = 3, B_LOOP = 4;
  localparam int L_CTS = 0, L_DSR = 1, L_RI = 2, L_DCD = 3;

  logic [CTL_W-1:0]                  ctl_r;
  logic [SYNC_STAGES-1:0][LN_W-1:0]  sync_r;
  logic [LN_W-1:0]                   line_r, delta_r, line_nx, flip, delta_set, pins;

  assign pins = {dcd_i, ri_i, dsr_i, cts_i};

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_r <= CTL_RST;
    else if (ctl_wr) ctl_r <= ctl_wdata[CTL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sync_r <= {SYNC_STAGES{LINE_RST}};
    else        sync_r <= {sync_r[SYNC_STAGES-2:0], pins};
  end

  assign line_nx = ctl_r[B_LOOP] ? {ctl_r[B_OUT2], ctl_r[B_OUT1], ctl_r[B_DTR], ctl_r[B_RTS]}
                                 : sync_r[SYNC_STAGES-1];
  assign flip    = line_nx ^ line_r;

  always_comb begin
    delta_set       = flip;
    delta_set[L_RI] = line_r[L_RI] & ~line_nx[L_RI];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_r  <= LINE_RST;
      delta_r <= '0;
    end else begin
      line_r  <= line_nx;
      delta_r <= (stat_rd ? '0 : delta_r) | delta_set;
    end
  end

  assign stat_q    = {line_r, delta_r};
  assign ctl_q     = {{(8-CTL_W){1'b0}}, ctl_r};
  assign rts_o     = ctl_r[B_RTS] & ~ctl_r[B_LOOP];
  assign dtr_o     = ctl_r[B_DTR] & ~ctl_r[B_LOOP];
  assign out1_o    = ctl_r[B_OUT1];
  assign out2_o    = ctl_r[B_OUT2];
  assign msc_chg_o = |delta_r;
endmodule

module modem_ctl_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctl_q,
  input logic       stat_rd,
  input logic [7:0] stat_q,
  input logic       rts_o,
  input logic       dtr_o,
  input logic       msc_chg_o
);
  AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ctl_q[7:5] == 3'b000); // R2
  AST_LOOP_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n) ctl_q[4] |-> (!rts_o && !dtr_o)); // R4
  AST_DCD_DELTA: assert property (@(posedge clk) disable iff (!rst_n) (stat_q[7] != $past(stat_q[7])) |-> stat_q[3]); // R6
  AST_DSR_DELTA: assert property (@(posedge clk) disable iff (!rst_n) (stat_q[5] != $past(stat_q[5])) |-> stat_q[1]); // R6
  AST_CTS_DELTA: assert property (@(posedge clk) disable iff (!rst_n) (stat_q[4] != $past(stat_q[4])) |-> stat_q[0]); // R6
  AST_RI_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n) $fell(stat_q[6]) |-> stat_q[2]); // R7
  AST_RI_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ($rose(stat_q[6]) && !$past(stat_q[2])) |-> !stat_q[2]); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) ($past(stat_rd) && $stable(stat_q[7:4])) |-> (stat_q[3:0] == 4'h0)); // R8
  AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !$past(stat_rd) |-> ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0]))); // R8
  AST_LOOP_CROSS: assert property (@(posedge clk) disable iff (!rst_n) $past(ctl_q[4]) |-> (stat_q[7:4] == {$past(ctl_q[3]), $past(ctl_q[2]), $past(ctl_q[0]), $past(ctl_q[1])})); // R9
  AST_CHANGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) msc_chg_o == (stat_q[3:0] != 4'h0)); // R10
endmodule

bind modem_ctl_stat modem_ctl_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .stat_rd(stat_rd), .stat_q(stat_q),
  .rts_o(rts_o), .dtr_o(dtr_o), .msc_chg_o(msc_chg_o)
);

// File: tb/modem_ctl_stat_bench.sv
module modem_ctl_stat_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 1'b0, stat_rd = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic cts_i = 1'b1, dsr_i = 1'b1, dcd_i = 1'b1, ri_i = 1'b0;
  logic [7:0] ctl_q, stat_q;
  logic rts_o, dtr_o, out1_o, out2_o, msc_chg_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  modem_ctl_stat #(.SYNC_STAGES(2)) u_modem_ctl_stat (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .stat_rd(stat_rd), .stat_q(stat_q), .cts_i(cts_i), .dsr_i(dsr_i), .dcd_i(dcd_i),
    .ri_i(ri_i), .rts_o(rts_o), .dtr_o(dtr_o), .out1_o(out1_o), .out2_o(out2_o),
    .msc_chg_o(msc_chg_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wdata = v; ctl_wr = 1'b1;
    edges(1);
    ctl_wr = 1'b0;
  endtask

  task automatic rd_stat(input string tag, input logic [7:0] exp_before, input logic [7:0] exp_after);
    chk({tag, " read value"}, stat_q, exp_before);
    stat_rd = 1'b1;
    edges(1);
    stat_rd = 1'b0;
    chk({tag, " after read"}, stat_q, exp_after);
  endtask

  function automatic logic [7:0] pins_out();
    return {4'h0, out2_o, out1_o, rts_o, dtr_o};
  endfunction

  task automatic t_reset();
    chk("R1 status", stat_q, 8'hB0);
    chk("R1 control", ctl_q, 8'h08);
    chk("R1 pins", pins_out(), 8'h08);
    chk("R1 change flag", {7'h0, msc_chg_o}, 8'h00);
  endtask

  task automatic t_control();
    wr_ctl(8'hE7);
    chk("R2 masked readback", ctl_q, 8'h07);
    chk("R3 pins 07", pins_out(), 8'h07);
    wr_ctl(8'h0A);
    chk("R3 pins 0A", pins_out(), 8'h0A);
    edges(1);
    chk("R6 no delta from control", stat_q, 8'hB0);
  endtask

  task automatic t_loopback();
    wr_ctl(8'h1F);
    chk("R4 loop pins", pins_out(), 8'h0C);
    edges(1);
    chk("R9 cross all ones, RI rise no TERI R7", stat_q, 8'hF0);
    cts_i = 0; dsr_i = 0; dcd_i = 0; ri_i = 1;
    edges(5);
    chk("R9 external ignored", stat_q, 8'hF0);
    cts_i = 1; dsr_i = 1; dcd_i = 1; ri_i = 0;
    edges(4);
    wr_ctl(8'h12);
    edges(1);
    chk("R9 RTS on bit4 only, deltas R6 R7", stat_q, 8'h1E);
    chk("R10 flag set", {7'h0, msc_chg_o}, 8'h01);
    rd_stat("R8 loop", 8'h1E, 8'h10);
    chk("R10 flag clear", {7'h0, msc_chg_o}, 8'h00);
    wr_ctl(8'h11);
    edges(1);
    chk("R9 DTR on bit5", stat_q, 8'h23);
    wr_ctl(8'h00);
    edges(1);
    chk("R6 loop exit", stat_q, 8'hBB);
    rd_stat("R8 exit", 8'hBB, 8'hB0);
  endtask

  task automatic t_latency();
    cts_i = 1'b0;
    edges(2);
    chk("R5 not before third edge", stat_q, 8'hB0);
    edges(1);
    chk("R5 CTS low on third edge R6", stat_q, 8'hA1);
    chk("R10 flag on change", {7'h0, msc_chg_o}, 8'h01);
  endtask

  task automatic t_ring();
    ri_i = 1'b1;
    edges(4);
    chk("R7 RI rise leaves TERI", stat_q, 8'hE1);
    ri_i = 1'b0;
    edges(4);
    chk("R7 RI fall sets TERI", stat_q, 8'hA5);
    rd_stat("R8 ring", 8'hA5, 8'hA0);
  endtask

  task automatic t_sticky();
    dsr_i = 1'b0;
    edges(4);
    chk("R6 DSR fall", stat_q, 8'h82);
    dsr_i = 1'b1;
    edges(4);
    chk("R8 delta sticky", stat_q, 8'hA2);
    rd_stat("R8 sticky", 8'hA2, 8'hA0);
  endtask

  task automatic t_collide();
    dcd_i = 1'b0;
    edges(2);
    stat_rd = 1'b1;
    edges(1);
    stat_rd = 1'b0;
    chk("R8 set wins over read", stat_q, 8'h28);
    rd_stat("R8 collide", 8'h28, 8'h20);
  endtask

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_control();
    t_loopback();
    t_latency();
    t_ring();
    t_sticky();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule